// File: doc/BRIEF.md
# Event-Triggered Single-Channel Transfer Controller

This block serves one peripheral. Each time the peripheral signals an event (for example, "a received byte is waiting"), the block reads one item from a source address and writes it to a destination address. It does this over a simple synchronous bus master that uses a ready handshake. After each transfer it updates both addresses according to their addressing modes and decrements a transfer count.

While a sequence is running, the peripheral's event is absorbed. On every intermediate transfer the block pulses a clear for the peripheral's data-ready flag. When the count runs out, the block disables itself, leaves the flag untouched and forwards the event to the CPU interrupt line. While the channel is disabled, events go straight to the CPU.

Software sets up five settings through a small register port: a mode word, the source address, the destination address, the count and the enable bit. The same port reads the live values back, so that the progress of a sequence can be watched.

Top module: `evx_channel`

## Requirements
- R1: After reset the bus request, the flag clear and the CPU interrupt are all low, and every register read at selects 0 to 4 returns 0. The selects are: 0 mode, 1 source, 2 destination, 3 count, 4 enable in bit 0.
- R2: While enable is 0, each one-cycle event produces exactly one one-cycle `cpu_irq_o` pulse and no bus cycle.
- R3: The mode word holds the source addressing in bits [1:0], the destination addressing in bits [3:2], the size in bits [7:6] and the interrupt select in bit 9. Source addressing 00 keeps the source address unchanged across transfers.
- R4: Each serviced event performs one bus read at the source address, then one bus write of the read data to the destination address. The count then decrements, and destination addressing 10 advances the destination address.
- R5: With interrupt select 0, a transfer that leaves a nonzero count produces one `flag_clr_o` pulse and no CPU interrupt.
- R6: With interrupt select 0, the transfer that brings the count to zero produces no flag clear and one CPU interrupt pulse, and it clears the enable bit.
- R7: Size 00, 01 and 10 give an address step of 1, 2 and 4 bytes, and `bus_size_o` carries the size code. Addressing 10 adds the step and 11 subtracts it.
- R8: An event that arrives while a transfer is in progress, including in the cycle the transfer completes, is held and serviced afterwards; it is never lost.
- R9: A bus cycle keeps its request, address and direction unchanged until `bus_rdy_i` is high.
- R10: With interrupt select 1, every transfer pulses the CPU interrupt and never the flag clear, and the enable bit still clears when the count reaches zero.
- R11: A count loaded as 0 stands for 65536 transfers: one transfer leaves 0xFFFF with the channel still enabled and the flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the select |
| evt_i | input | 1 | One-cycle peripheral event |
| flag_clr_o | output | 1 | One-cycle clear of the peripheral data-ready flag |
| cpu_irq_o | output | 1 | One-cycle interrupt pulse to the CPU |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | DW | Bus write data |
| bus_size_o | output | 2 | Transfer size code |
| bus_rdata_i | input | DW | Bus read data |
| bus_rdy_i | input | 1 | Bus cycle completes |

## Verification
Two functions can land in the same cycle: the arrival of a new peripheral event and the completion step of the current transfer, in which the count and addresses update and the flag clear is issued. The bench times a second event so that the block samples it exactly in the completion cycle. It then judges from the bus traffic and the read-back count that both events were serviced. A separate event that lands in the middle of the read phase checks the ordinary pending path.

// File: rtl/evx_pkg.sv
package evx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_DONE = 2'd3
   } seq_st_t;

   // packed mode word, LSB field last
   typedef struct packed {
      logic [5:0] rsvd;
      logic       isel;
      logic       chain;
      logic [1:0] size;
      logic [1:0] xmode;
      logic [1:0] dmode;
      logic [1:0] smode;
   } mode_t;

   localparam logic [1:0] AM_INC = 2'b10;
   localparam logic [1:0] AM_DEC = 2'b11;

   localparam logic [2:0] SEL_MODE = 3'd0;
   localparam logic [2:0] SEL_SRC  = 3'd1;
   localparam logic [2:0] SEL_DST  = 3'd2;
   localparam logic [2:0] SEL_CNT  = 3'd3;
   localparam logic [2:0] SEL_EN   = 3'd4;

endpackage

// File: rtl/evx_addr_step.sv
module evx_addr_step
   import evx_pkg::*;
#(
   parameter int AW        = 32,
   parameter bit ALLOW_DEC = 1'b1
) (
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    amode_i,
   input  logic [1:0]    size_i,
   output logic [AW-1:0] addr_o
);

   logic [AW-1:0] step;

   always_comb begin
      case (size_i)
         2'b00:   step = AW'(1);
         2'b01:   step = AW'(2);
         default: step = AW'(4);
      endcase
   end

   generate
      if (ALLOW_DEC) begin : g_updown
         always_comb begin
            case (amode_i)
               AM_INC:  addr_o = addr_i + step;
               AM_DEC:  addr_o = addr_i - step;
               default: addr_o = addr_i;
            endcase
         end
      end else begin : g_uponly
         always_comb begin
            addr_o = (amode_i == AM_INC) ? addr_i + step : addr_i;
         end
      end
   endgenerate

endmodule

// File: rtl/evx_seq.sv
module evx_seq
   import evx_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [1:0]    size_i,
   input  logic [DW-1:0] bus_rdata_i,
   input  logic          bus_rdy_i,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   output logic [1:0]    bus_size_o,
   output logic          busy_o,
   output logic          done_o
);

   seq_st_t       st_q;
   logic [DW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hold_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start_i) st_q <= ST_RD;
            ST_RD: if (bus_rdy_i) begin
               hold_q <= bus_rdata_i;
               st_q   <= ST_WR;
            end
            ST_WR: if (bus_rdy_i) st_q <= ST_DONE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
      bus_we_o    = (st_q == ST_WR);
      bus_addr_o  = (st_q == ST_WR) ? dst_i : src_i;
      bus_wdata_o = hold_q;
      bus_size_o  = size_i;
      busy_o      = (st_q != ST_IDLE);
      done_o      = (st_q == ST_DONE);
   end

   // R9: a waiting bus cycle must not move
   p_hold_until_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_rdy_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

   // R4: every transfer opens with a read
   p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req_o) |-> !bus_we_o);

   // R4: a finished read is followed by the write
   p_write_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_we_o && bus_rdy_i) |=> (bus_req_o && bus_we_o));

endmodule

// File: rtl/evx_channel.sv
module evx_channel
   import evx_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter bit ALLOW_DEC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata,
   input  logic          evt_i,
   output logic          flag_clr_o,
   output logic          cpu_irq_o,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   output logic [1:0]    bus_size_o,
   input  logic [DW-1:0] bus_rdata_i,
   input  logic          bus_rdy_i
);

   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("evx_channel: AW must lie in 8..32");
      end
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("evx_channel: CW must lie in 2..32");
      end
      if (DW < 32 || (DW % 8) != 0) begin : g_bad_dw
         $error("evx_channel: DW must be a byte multiple of at least 32");
      end
   endgenerate

   mode_t         mode_q;
   logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
   logic [CW-1:0] cnt_q;
   logic          en_q, pend_q, clr_q, irq_q;
   logic          start, busy, done, last;

   assign start = en_q && pend_q && !busy;
   assign last  = (cnt_q == CNT_ONE);

   evx_addr_step #(.AW(AW), .ALLOW_DEC(ALLOW_DEC)) u_src_step (
      .addr_i(src_q), .amode_i(mode_q.smode), .size_i(mode_q.size), .addr_o(src_nx));

   evx_addr_step #(.AW(AW), .ALLOW_DEC(ALLOW_DEC)) u_dst_step (
      .addr_i(dst_q), .amode_i(mode_q.dmode), .size_i(mode_q.size), .addr_o(dst_nx));

   evx_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .src_i(src_q), .dst_i(dst_q), .size_i(mode_q.size),
      .bus_rdata_i(bus_rdata_i), .bus_rdy_i(bus_rdy_i),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_size_o(bus_size_o),
      .busy_o(busy), .done_o(done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         clr_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         irq_q <= evt_i && !en_q;
         if (start) pend_q <= 1'b0;
         if (cfg_we) begin
            case (cfg_addr)
               SEL_MODE: mode_q <= mode_t'(cfg_wdata[15:0]);
               SEL_SRC:  src_q  <= cfg_wdata[AW-1:0];
               SEL_DST:  dst_q  <= cfg_wdata[AW-1:0];
               SEL_CNT:  cnt_q  <= cfg_wdata[CW-1:0];
               SEL_EN: begin
                  en_q   <= cfg_wdata[0];
                  pend_q <= 1'b0;
               end
               default: ;
            endcase
         end
         if (done) begin
            src_q <= src_nx;
            dst_q <= dst_nx;
            cnt_q <= cnt_q - CNT_ONE;
            if (last) begin
               en_q   <= 1'b0;
               pend_q <= 1'b0;
            end
            irq_q <= last || mode_q.isel;
            clr_q <= !last && !mode_q.isel;
         end
         if (evt_i && en_q) pend_q <= 1'b1;
      end
   end

   always_comb begin
      case (cfg_addr)
         SEL_MODE: cfg_rdata = {16'b0, mode_q};
         SEL_SRC:  cfg_rdata = 32'(src_q);
         SEL_DST:  cfg_rdata = 32'(dst_q);
         SEL_CNT:  cfg_rdata = 32'(cnt_q);
         SEL_EN:   cfg_rdata = {31'b0, en_q};
         default:  cfg_rdata = '0;
      endcase
   end

   assign flag_clr_o = clr_q;
   assign cpu_irq_o  = irq_q;

   // R2: the bus is used only by an enabled channel
   p_bus_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o |-> en_q);

   // R5: flag clear and CPU interrupt never coincide
   p_clr_excl_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_clr_o && cpu_irq_o));

   // R5: a flag clear means the sequence is still running
   p_clr_keeps_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr_o |-> (en_q && cnt_q != '0));

   // R6: a completion with count one disables the channel
   p_last_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && last && !cfg_we) |=> (!en_q && cpu_irq_o));

endmodule

// File: tb/sim_evx_channel.sv
module sim_evx_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = 3'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] cfg_rdata;
   logic        evt = 1'b0;
   logic        flag_clr, cpu_irq, bus_req, bus_we, bus_rdy;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic [1:0]  bus_size;
   logic [3:0]  wcnt = 4'd0;

   int total = 0, bad = 0;
   int irq_cnt = 0, clr_cnt = 0, wr_seen = 0;
   int bw = 0;

   typedef struct {
      logic [31:0] a;
      logic [31:0] d;
      logic [1:0]  s;
      string       tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   evx_channel u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_i(evt),
      .flag_clr_o(flag_clr), .cpu_irq_o(cpu_irq), .bus_req_o(bus_req),
      .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
      .bus_size_o(bus_size), .bus_rdata_i(bus_rdata), .bus_rdy_i(bus_rdy));

   function automatic logic [31:0] fdat(input logic [31:0] a);
      return {a[7:0] ^ 8'h3C, a[15:8], 8'h77, a[7:0]};
   endfunction

   assign bus_rdata = fdat(bus_addr);
   assign bus_rdy   = bus_req && (int'(wcnt) >= bw);

   always @(posedge clk) begin
      if (!bus_req || bus_rdy) wcnt <= 4'd0;
      else wcnt <= wcnt + 4'd1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (cpu_irq) irq_cnt++;
         if (flag_clr) clr_cnt++;
         if (bus_req && bus_we && bus_rdy) begin
            wr_seen++;
            if (q.size() == 0) begin
               total++;
               bad++;
               $display("FAIL R4 unexpected write act=%h exp=none", bus_addr);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({e.tag, " addr"}, bus_addr, e.a);
               chk({e.tag, " data"}, bus_wdata, e.d);
               chk({e.tag, " size"}, 32'(bus_size), 32'(e.s));
            end
         end
      end
   end

   task automatic push(input logic [31:0] a, input logic [31:0] src,
                       input logic [1:0] s, input string tag);
      exp_t e;
      e.a = a; e.d = fdat(src); e.s = s; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic fire();
      @(negedge clk);
      evt = 1'b1;
      @(negedge clk);
      evt = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(input logic [31:0] m, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] c);
      wr(3'd0, m); wr(3'd1, s); wr(3'd2, d); wr(3'd3, c); wr(3'd4, 32'd1);
   endtask

   initial begin
      #4000000;
      total++;
      bad++;
      $display("FAIL watchdog R8 act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int i0, c0;
      settle(3);
      // R1 reset state
      chk("R1 bus_req", 32'(bus_req), 0);
      chk("R1 irq", 32'(cpu_irq), 0);
      chk("R1 clr", 32'(flag_clr), 0);
      for (int k = 0; k < 5; k++) begin
         rd(3'(k), v);
         chk("R1 reg", v, 0);
      end
      rst_n = 1'b1;
      settle(2);

      // R2 bypass
      i0 = irq_cnt;
      fire();
      settle(3);
      chk("R2 irq pulses", 32'(irq_cnt - i0), 1);
      chk("R2 no bus", 32'(wr_seen), 0);

      // R3 R4 R5 R6 byte, fixed source, incrementing destination
      setup(32'h0008, 32'h100, 32'h2000, 32'd3);
      i0 = irq_cnt; c0 = clr_cnt;
      for (int k = 0; k < 3; k++) begin
         push(32'h2000 + k, 32'h100, 2'b00, "R4 byte");
         fire();
         settle(12);
         if (k == 0) begin
            chk("R5 clr after first", 32'(clr_cnt - c0), 1);
            chk("R5 no irq mid", 32'(irq_cnt - i0), 0);
         end
      end
      chk("R6 clr total", 32'(clr_cnt - c0), 2);
      chk("R6 irq at end", 32'(irq_cnt - i0), 1);
      rd(3'd4, v); chk("R6 en cleared", v, 0);
      rd(3'd3, v); chk("R4 count zero", v, 0);
      rd(3'd2, v); chk("R4 dst advanced", v, 32'h2003);
      rd(3'd1, v); chk("R3 src fixed", v, 32'h100);

      // R7 word, source up, destination down
      setup(32'h004E, 32'h300, 32'h4010, 32'd2);
      push(32'h4010, 32'h300, 2'b01, "R7 word");
      fire(); settle(12);
      push(32'h400E, 32'h302, 2'b01, "R7 word");
      fire(); settle(12);
      rd(3'd1, v); chk("R7 src word step", v, 32'h304);
      rd(3'd2, v); chk("R7 dst word dec", v, 32'h400C);

      // R7 longword, both up
      setup(32'h008A, 32'h500, 32'h6000, 32'd2);
      push(32'h6000, 32'h500, 2'b10, "R7 long");
      fire(); settle(12);
      push(32'h6004, 32'h504, 2'b10, "R7 long");
      fire(); settle(12);
      rd(3'd1, v); chk("R7 src long step", v, 32'h508);

      // R8 event during the read phase
      setup(32'h0008, 32'h100, 32'h7000, 32'd5);
      c0 = clr_cnt; i0 = wr_seen;
      push(32'h7000, 32'h100, 2'b00, "R8 busy");
      push(32'h7001, 32'h100, 2'b00, "R8 busy");
      fire(); fire();
      settle(20);
      chk("R8 both served", 32'(wr_seen - i0), 2);
      rd(3'd3, v); chk("R8 count", v, 3);

      // R8 event in the completion cycle
      push(32'h7002, 32'h100, 2'b00, "R8 collide");
      push(32'h7003, 32'h100, 2'b00, "R8 collide");
      fire(); settle(2); fire();
      settle(20);
      chk("R8 collide served", 32'(wr_seen - i0), 4);
      rd(3'd3, v); chk("R8 collide count", v, 1);
      chk("R8 clr count", 32'(clr_cnt - c0), 4);
      wr(3'd4, 32'd0);

      // R9 wait states
      bw = 3;
      setup(32'h0008, 32'h180, 32'h7800, 32'd2);
      push(32'h7800, 32'h180, 2'b00, "R9 wait");
      fire(); settle(25);
      rd(3'd3, v); chk("R9 count", v, 1);
      rd(3'd2, v); chk("R9 dst", v, 32'h7801);
      bw = 0;
      wr(3'd4, 32'd0);

      // R10 interrupt on every transfer
      setup(32'h0208, 32'h100, 32'h7A00, 32'd2);
      i0 = irq_cnt; c0 = clr_cnt;
      push(32'h7A00, 32'h100, 2'b00, "R10");
      fire(); settle(12);
      chk("R10 irq first", 32'(irq_cnt - i0), 1);
      push(32'h7A01, 32'h100, 2'b00, "R10");
      fire(); settle(12);
      chk("R10 irq both", 32'(irq_cnt - i0), 2);
      chk("R10 no clr", 32'(clr_cnt - c0), 0);
      rd(3'd4, v); chk("R10 en cleared", v, 0);

      // R11 zero count
      setup(32'h0008, 32'h100, 32'h7C00, 32'd0);
      i0 = irq_cnt; c0 = clr_cnt;
      push(32'h7C00, 32'h100, 2'b00, "R11");
      fire(); settle(12);
      rd(3'd3, v); chk("R11 count wraps", v, 32'hFFFF);
      rd(3'd4, v); chk("R11 still enabled", v, 1);
      chk("R11 clr", 32'(clr_cnt - c0), 1);
      chk("R11 no irq", 32'(irq_cnt - i0), 0);

      chk("R4 scoreboard drained", 32'(q.size()), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule